// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is an I2C target that serves reads from a 256-byte array. It samples SCL and SDA on the system clock, synchronizes and oversamples both lines, and detects START, repeated START and STOP conditions. It drives SDA only as an open-drain pull-down enable. A 7-bit device address selects the block. The address is a fixed four-bit family code of binary 1010 followed by three select bits, and those select bits are compared with strap inputs.

A persistent byte pointer survives from one transaction to the next. A write-direction header followed by one word-address byte loads the pointer and does not change the array. This is the "dummy write" that opens a random read. A read-direction header then streams bytes from the pointer. The master can also issue a read header on its own to continue where the previous read stopped. For each byte it acknowledges, the block sends another byte. When the master does not acknowledge, the block goes quiet until the next STOP or START.

A synchronous preload port fills the array from the local side. Programming cycles are not part of this block.

Top module: `i2crd_target`

## Requirements
- R1: After reset SDA is released, and the first read-direction header with no prior word address returns the byte at address 0.
- R2: A header whose upper seven bits equal 1010 followed by `sel_i[2:0]` (bit 7 first) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of the header selects the direction: 0 is write and 1 is read.
- R3: A header with a different family code or different select bits is not acknowledged. SDA stays released for the rest of that transaction, and the pointer does not change.
- R4: A write header, then a word-address byte (both acknowledged), then a repeated START and a read header return the byte at that word address.
- R5: A read header sent alone returns the byte at the pointer. After any read the pointer equals the last transmitted address plus one.
- R6: While the master acknowledges each data byte (SDA low in the ninth clock), the block sends the byte at the next address.
- R7: The pointer wraps from 255 to 0 during a sequential read.
- R8: When the master leaves the acknowledge slot high, the block releases SDA and drives nothing more until a STOP or START.
- R9: The word-address byte loads the pointer even when a STOP follows it directly.
- R10: Data bytes are sent most significant bit first, one bit per SCL clock, in the eight clocks before the acknowledge slot.
- R11: The SDA drive changes only while SCL is low.
- R12: A STOP or START in any state, including in the middle of a byte, returns the block to idle or to header reception, and the pointer value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_i | input | 3 | Device select straps compared with header bits 3..1 |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | ADDR_W | Preload address |
| pre_data_i | input | 8 | Preload data |

## Verification
A pointer that is wrong after a STOP, a mismatched header or an aborted word address does not show up when it happens. It appears on SDA in the first byte of the next current-address read, so every scenario ends with such a read. A wrong bit counter or state shows within one byte as a missing or misplaced acknowledge, or as a shifted data value. A drive that is not released after a not-acknowledge shows within the next clock as a low level that the master did not drive.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_HACK,
      ST_WADR,
      ST_WACK,
      ST_TX,
      ST_MACK,
      ST_SKIP
   } rd_state_e;

   localparam int BYTE_W = 8;
   localparam logic [3:0] FAMILY_CODE = 4'b1010;
endpackage

// File: rtl/i2crd_line_sync.sv
module i2crd_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // SDA edges count only while SCL is high on both samples
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2crd_store.sv
module i2crd_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/i2crd_engine.sv
module i2crd_engine
   import i2crd_pkg::*;
#(
   parameter int         ADDR_W = 8,
   parameter logic [3:0] FAMILY = FAMILY_CODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [2:0]        sel,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              ptr_load,
   output logic              sda_oe,
   output rd_state_e         state,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam logic [3:0] LAST_BIT = 4'd8;

   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-2:0] tx_sr;
   logic [3:0]        bit_cnt;
   logic              rw_q;
   logic              mack_q;
   logic              hdr_hit;

   assign hdr_hit = (rx_sr[7:1] == {FAMILY, sel});
   assign rx_byte = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         ptr      <= '0;
         ptr_load <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         ptr_load <= 1'b0;
         if (start_det) begin
            state   <= ST_HDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_HDR, ST_WADR: begin
                  if (scl_rise) begin
                     rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == LAST_BIT) begin
                     if (state == ST_HDR) begin
                        if (hdr_hit) begin
                           state  <= ST_HACK;
                           sda_oe <= 1'b1;
                           rw_q   <= rx_sr[0];
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        state    <= ST_WACK;
                        sda_oe   <= 1'b1;
                        ptr      <= rx_sr[ADDR_W-1:0];
                        ptr_load <= 1'b1;
                     end
                  end
               end
               ST_HACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        tx_sr   <= rd_data[BYTE_W-2:0];
                        sda_oe  <= ~rd_data[BYTE_W-1];
                        ptr     <= ptr + 1'b1;
                        bit_cnt <= 4'd1;
                        state   <= ST_TX;
                     end else begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WADR;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_SKIP;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else begin
                        sda_oe  <= ~tx_sr[BYTE_W-2];
                        tx_sr   <= {tx_sr[BYTE_W-3:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_sr   <= rd_data[BYTE_W-2:0];
                        sda_oe  <= ~rd_data[BYTE_W-1];
                        ptr     <= ptr + 1'b1;
                        bit_cnt <= 4'd1;
                        state   <= ST_TX;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2crd_target.sv
module i2crd_target
   import i2crd_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        sel_i,
   input  logic              pre_we_i,
   input  logic [ADDR_W-1:0] pre_addr_i,
   input  logic [BYTE_W-1:0] pre_data_i
);
   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between 1 and 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              w_sda_s;
   logic              w_scl_rise;
   logic              w_scl_fall;
   logic              w_start;
   logic              w_stop;
   logic [ADDR_W-1:0] w_ptr;
   logic              w_ptr_load;
   logic [BYTE_W-1:0] w_rd_data;
   logic [BYTE_W-1:0] w_rx_byte;
   rd_state_e         w_state;

   i2crd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (w_sda_s),
      .scl_rise  (w_scl_rise),
      .scl_fall  (w_scl_fall),
      .start_det (w_start),
      .stop_det  (w_stop)
   );

   i2crd_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
      .clk     (clk),
      .wr_en   (pre_we_i),
      .wr_addr (pre_addr_i),
      .wr_data (pre_data_i),
      .rd_addr (w_ptr),
      .rd_data (w_rd_data)
   );

   i2crd_engine #(.ADDR_W(ADDR_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (w_scl_rise),
      .scl_fall  (w_scl_fall),
      .start_det (w_start),
      .stop_det  (w_stop),
      .sda_s     (w_sda_s),
      .sel       (sel_i),
      .rd_data   (w_rd_data),
      .ptr       (w_ptr),
      .ptr_load  (w_ptr_load),
      .sda_oe    (sda_oe_o),
      .state     (w_state),
      .rx_byte   (w_rx_byte)
   );
endmodule

// File: rtl/i2crd_target_chk.sv
module i2crd_target_chk
   import i2crd_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic [2:0]        sel_i,
   input logic              sda_oe_o,
   input logic              start_det,
   input logic              stop_det,
   input logic [ADDR_W-1:0] ptr,
   input logic              ptr_load,
   input rd_state_e         state,
   input logic [BYTE_W-1:0] rx_byte
);
   localparam logic [ADDR_W-1:0] ONE = 1;

   // R11: drive is steady across any SCL-high interval
   assert_sda_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

   // R12: STOP releases the line and parks the engine
   assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe_o && state == ST_IDLE));

   // R12: bus conditions leave the pointer untouched
   assert_cond_keep_ptr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> (ptr == $past(ptr)));

   // R7: outside a word-address load the pointer only steps by one, modulo depth
   assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ptr != $past(ptr)) && !ptr_load) |-> (ptr == $past(ptr) + ONE));

   // R2: header acknowledge only for a matching address
   assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HACK) |-> (rx_byte[7:1] == {FAMILY_CODE, sel_i}));

   // R3, R8: ignored transactions never pull the line
   assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe_o);
endmodule

bind i2crd_target i2crd_target_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sel_i     (sel_i),
   .sda_oe_o  (sda_oe_o),
   .start_det (w_start),
   .stop_det  (w_stop),
   .ptr       (w_ptr),
   .ptr_load  (w_ptr_load),
   .state     (w_state),
   .rx_byte   (w_rx_byte)
);

// File: tb/test_i2crd_target.sv
module test_i2crd_target;
   localparam int Q = 4;
   localparam logic [2:0] SEL = 3'b101;
   localparam logic [7:0] HDR_W = {4'b1010, SEL, 1'b0};
   localparam logic [7:0] HDR_R = {4'b1010, SEL, 1'b1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_oe_o;
   logic       pre_we = 1'b0;
   logic [7:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic       sda_bus;

   assign sda_bus = !(m_low || sda_oe_o);

   always #5 clk = ~clk;

   i2crd_target i_i2crd_target (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .sda_oe_o   (sda_oe_o),
      .sel_i      (SEL),
      .pre_we_i   (pre_we),
      .pre_addr_i (pre_addr),
      .pre_data_i (pre_data)
   );

   int         n_chk = 0;
   int         n_fail = 0;
   int         n_r11_viol = 0;
   logic [7:0] ref_mem [256];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] obs_byte;
   event       byte_ev;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(byte_ev);
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected byte", obs_byte, 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(obs_byte == e, t, obs_byte, e);
         end
      end
   end

   // R11 watcher on the drive enable
   always @(sda_oe_o) begin
      if (rst_n && scl === 1'b1) n_r11_viol++;
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic wait_q;
      repeat (Q) @(negedge clk);
   endtask

   task automatic do_start;
      m_low = 1'b0; wait_q();
      scl = 1'b1;   wait_q();
      m_low = 1'b1; wait_q();
      scl = 1'b0;   wait_q();
   endtask

   task automatic do_stop;
      m_low = 1'b1; wait_q();
      scl = 1'b1;   wait_q();
      m_low = 1'b0; wait_q();
   endtask

   task automatic clk_bit(input logic b, output logic s);
      m_low = !b; wait_q();
      scl = 1'b1; wait_q();
      s = sda_bus; wait_q();
      scl = 1'b0; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      check((!s) == exp_ack, tag, !s, exp_ack);
   endtask

   task automatic recv_byte(input bit master_ack);
      logic s;
      logic [7:0] v;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         v = {v[6:0], s};
      end
      clk_bit(!master_ack, s);
      obs_byte = v;
      ->byte_ev;
   endtask

   task automatic expect_run(input int first, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(ref_mem[(first + i) % 256]);
         tag_q.push_back(tag);
      end
   endtask

   task automatic read_n(input int n);
      for (int i = 0; i < n; i++) recv_byte(i < n - 1);
   endtask

   task automatic cur_read(input int first, input int n, input string tag);
      expect_run(first, n, tag);
      do_start();
      send_byte(HDR_R, 1'b1, "R2 read header ack");
      read_n(n);
      do_stop();
   endtask

   task automatic rand_read(input logic [7:0] a, input int n, input string tag);
      expect_run(a, n, tag);
      do_start();
      send_byte(HDR_W, 1'b1, "R2 write header ack");
      send_byte(a, 1'b1, "R4 word address ack");
      do_start();
      send_byte(HDR_R, 1'b1, "R2 read header ack");
      read_n(n);
      do_stop();
   endtask

   task automatic released_bits(input int n, input string tag);
      logic s;
      int lows;
      lows = 0;
      for (int i = 0; i < n; i++) begin
         clk_bit(1'b1, s);
         if (!s) lows++;
      end
      check(lows == 0, tag, lows, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'((i * 37 + 11) & 255);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         pre_we = 1'b1; pre_addr = 8'(i); pre_data = ref_mem[i];
      end
      @(negedge clk);
      pre_we = 1'b0;
      wait_q();

      // R1: released line, pointer starts at 0
      check(sda_bus == 1'b1, "R1 SDA released after reset", sda_bus, 1);
      cur_read(0, 1, "R1 current read after reset");

      // R4 + R10: random read, value with asymmetric bits
      rand_read(8'h40, 1, "R4 R10 random read at 0x40");
      // R5: continue at last+1
      cur_read(8'h41, 1, "R5 current read continues");
      // R6: sequential stream
      rand_read(8'h80, 5, "R6 sequential stream");
      // R7: wrap
      rand_read(8'hFD, 5, "R7 wrap 255 to 0");
      cur_read(8'h02, 1, "R7 pointer after wrap");

      // R8: master NACK, block stays silent
      rand_read(8'h10, 1, "R8 byte before nack");
      do_start();
      send_byte(HDR_R, 1'b1, "R2 read header ack");
      expect_run(8'h11, 1, "R8 read then nack");
      recv_byte(1'b0);
      released_bits(9, "R8 silent after nack");
      do_stop();
      cur_read(8'h12, 1, "R8 pointer after nack");

      // R3: wrong select bits and wrong family code
      do_start();
      send_byte({4'b1010, 3'b011, 1'b0}, 1'b0, "R3 wrong select no ack");
      send_byte(8'h77, 1'b0, "R3 ignored word byte no ack");
      do_stop();
      do_start();
      send_byte({4'b1001, SEL, 1'b1}, 1'b0, "R3 wrong family no ack");
      released_bits(9, "R3 silent after mismatch");
      do_stop();
      cur_read(8'h13, 1, "R3 pointer unchanged");

      // R9: dummy write then STOP
      do_start();
      send_byte(HDR_W, 1'b1, "R2 write header ack");
      send_byte(8'h20, 1'b1, "R9 word address ack");
      do_stop();
      cur_read(8'h20, 1, "R9 pointer loaded by word address");

      // R12: STOP in the middle of the word address
      do_start();
      send_byte(HDR_W, 1'b1, "R2 write header ack");
      begin
         logic s;
         for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
      end
      do_stop();
      cur_read(8'h21, 1, "R12 pointer kept after mid-byte STOP");

      // R12: repeated START right after the write header
      do_start();
      send_byte(HDR_W, 1'b1, "R2 write header ack");
      expect_run(8'h22, 2, "R12 pointer kept after repeated START");
      do_start();
      send_byte(HDR_R, 1'b1, "R2 read header ack");
      read_n(2);
      do_stop();

      wait_q();
      check(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
      check(n_r11_viol == 0, "R11 drive change while SCL high", n_r11_viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule